// File: doc/BRIEF.md
# Programmable-Resolution Message Time Tag

This block keeps a 16-bit time tag for a serial command/response bus terminal. A divider turns the system clock into a 1 µs timebase. A prescaler then stretches that timebase to one of six resolutions, from 2 µs to 64 µs per count. For self-test, the host can stop the timebase and step the counter one count at a time with a strobe.

The host can read the counter at any time and overwrite it. The mode-command decoder supplies two strobes for the synchronize commands. Each is gated by its own enable: one clears the counter, and the other loads it with the received data word. Each time the counter wraps from all ones to zero, the block emits a one-cycle rollover event for the interrupt status logic. When the message engine signals the end of a message, the block captures the counter value as the time tag word for the descriptor stack.

Top module: `msg_time_tag`

## Requirements
- R1: After reset the counter reads 0x0000, `rolloverEvt` and `tagWordValid` are low, and `tagWord` is 0x0000.
- R2: When `swStepMode` is low, the counter advances by one every 2^(resCode+1) × CLK_PER_US clocks for resCode 0 to 5. This gives 2, 4, 8, 16, 32 or 64 µs per count. Codes 6 and 7 act as code 5.
- R3: When `hostWrEn` is high, the counter takes `hostWrData` at the next edge. A host write wins over every other source of change. It also restarts the timebase, so the next increment comes one full period after the write.
- R4: When `swStepMode` is high, the counter advances by exactly one on each cycle with `swIncStb` high, and the timebase does not move it. After step mode is left, the first increment comes one full period later.
- R5: When `swStepMode` is low, `swIncStb` has no effect on the counter.
- R6: When `syncClrEn` is high, a cycle with `syncNoDataStb` high clears the counter and restarts the timebase. When `syncClrEn` is low, the strobe has no effect.
- R7: When `syncLoadEn` is high, a cycle with `syncDataStb` high loads `syncDataWord` and restarts the timebase. When `syncLoadEn` is low, the strobe has no effect. If the load and the clear occur in the same cycle, the load wins.
- R8: `rolloverEvt` is high for exactly the one cycle after an increment takes the counter from 0xFFFF to 0x0000. A host write, load or clear never raises it.
- R9: A cycle with `msgDoneStb` high makes `tagWordValid` high for one cycle after the edge. `tagWord` then carries the counter value seen in the strobe cycle and holds that value until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resCode | input | 3 | Resolution select, 2^(code+1) µs per count |
| swStepMode | input | 1 | Software step mode select |
| syncClrEn | input | 1 | Enable clear on synchronize without data |
| syncLoadEn | input | 1 | Enable load on synchronize with data |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 16 | Host write value |
| swIncStb | input | 1 | Software increment strobe |
| syncNoDataStb | input | 1 | Synchronize-without-data command seen |
| syncDataStb | input | 1 | Synchronize-with-data command seen |
| syncDataWord | input | 16 | Data word of the synchronize command |
| msgDoneStb | input | 1 | Message processed, capture time tag |
| tagCount | output | 16 | Current counter value for host read |
| rolloverEvt | output | 1 | One-cycle wrap event |
| tagWordValid | output | 1 | Captured time tag word valid |
| tagWord | output | 16 | Captured time tag word |

## Verification
The hardest case to reach is a wrap of the free-running counter. At 2 µs per count, reaching it from reset takes more than half a million clocks. The stimulus therefore writes a value a few counts below 0xFFFF and lets the timebase carry the counter across the boundary. It repeats this in step mode, and it also writes zero over 0xFFFF to show that no rollover event follows. Restarts of the timebase in the middle of a period come from host writes and synchronize strobes placed at arbitrary cycles. A cycle-by-cycle model checks that the following increment lands a full period later.

// File: rtl/tt_pkg.sv
package tt_pkg;

  localparam int TAG_W = 16;

  // Strobes from control to datapath; at most one of the load kinds is set.
  typedef struct packed {
    logic ldHost;
    logic ldSync;
    logic clr;
    logic inc;
  } ttStrobe_t;

  // Highest usable resolution code; larger codes saturate here.
  localparam logic [2:0] MAX_RES_CODE = 3'd5;

endpackage

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tt_pkg::*;
#(
  parameter int CLK_PER_US = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [2:0] resCode,
  input  logic      swStepMode,
  input  logic      syncClrEn,
  input  logic      syncLoadEn,
  input  logic      hostWrEn,
  input  logic      swIncStb,
  input  logic      syncNoDataStb,
  input  logic      syncDataStb,
  output ttStrobe_t strobes
);

  localparam int US_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic       usTick;
  logic [5:0] preCnt;
  logic [2:0] effCode;
  logic [6:0] perLimit;
  logic       endOfPeriod;
  logic       syncLoadHit;
  logic       syncClrHit;
  logic       phaseRst;
  logic       holdPhase;

  // Priority: host write, then synchronize load, then synchronize clear.
  assign syncLoadHit = syncLoadEn && syncDataStb;
  assign syncClrHit  = syncClrEn && syncNoDataStb;
  assign phaseRst    = hostWrEn || syncLoadHit || syncClrHit;
  assign holdPhase   = phaseRst || swStepMode;

  assign effCode  = (resCode > MAX_RES_CODE) ? MAX_RES_CODE : resCode;
  assign perLimit = 7'd2 << effCode;

  // 1 us timebase; a single clock per microsecond needs no counter.
  generate
    if (CLK_PER_US == 1) begin : g_noDiv
      assign usTick = 1'b1;
    end else begin : g_div
      logic [US_W-1:0] usCnt;
      assign usTick = (usCnt == US_W'(CLK_PER_US - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          usCnt <= '0;
        end else if (holdPhase || usTick) begin
          usCnt <= '0;
        end else begin
          usCnt <= usCnt + 1'b1;
        end
      end
    end
  endgenerate

  // A code change mid-period may leave preCnt above the new limit; >= ends it.
  assign endOfPeriod = usTick && ({1'b0, preCnt} >= (perLimit - 7'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (holdPhase) begin
      preCnt <= '0;
    end else if (usTick) begin
      preCnt <= endOfPeriod ? 6'd0 : preCnt + 6'd1;
    end
  end

  always_comb begin
    strobes        = '0;
    strobes.ldHost = hostWrEn;
    strobes.ldSync = !hostWrEn && syncLoadHit;
    strobes.clr    = !hostWrEn && !syncLoadHit && syncClrHit;
    if (!phaseRst) begin
      strobes.inc = swStepMode ? swIncStb : endOfPeriod;
    end
  end

  // R4: in step mode only the software strobe may advance the count
  a_r4_step_only: assert property (@(posedge clk) disable iff (!rst_n)
    (swStepMode && !swIncStb) |-> !strobes.inc);

  // R5: the software strobe alone never advances a free-running count
  a_r5_sw_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!swStepMode && !usTick) |-> !strobes.inc);

  // R3: a host write excludes every other change
  a_r3_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hostWrEn |-> !(strobes.ldSync || strobes.clr || strobes.inc));

  // R3/R6/R7: any load or clear restarts the prescaler
  a_r3_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    phaseRst |=> (preCnt == 6'd0));

endmodule

// File: rtl/tt_datapath.sv
module tt_datapath
  import tt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ttStrobe_t        strobes,
  input  logic [TAG_W-1:0] hostWrData,
  input  logic [TAG_W-1:0] syncDataWord,
  input  logic             msgDoneStb,
  output logic [TAG_W-1:0] count,
  output logic             rolloverEvt,
  output logic             tagWordValid,
  output logic [TAG_W-1:0] tagWord
);

  logic [TAG_W-1:0] countNext;
  logic             wrapNow;

  assign wrapNow = strobes.inc && (&count);

  always_comb begin
    countNext = count;
    if (strobes.ldHost) begin
      countNext = hostWrData;
    end else if (strobes.ldSync) begin
      countNext = syncDataWord;
    end else if (strobes.clr) begin
      countNext = '0;
    end else if (strobes.inc) begin
      countNext = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count        <= '0;
      rolloverEvt  <= 1'b0;
      tagWordValid <= 1'b0;
      tagWord      <= '0;
    end else begin
      count        <= countNext;
      rolloverEvt  <= wrapNow;
      tagWordValid <= msgDoneStb;
      if (msgDoneStb) begin
        tagWord <= count;
      end
    end
  end

  // R8: the event follows only a wrap from all ones to zero
  a_r8_rollover_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    rolloverEvt |-> ((count == '0) && ($past(count) == '1)));

  // R3: a host write lands on the next edge
  a_r3_host_load: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.ldHost |=> (count == $past(hostWrData)));

  // R9: valid pulse only after a capture strobe
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tagWordValid |-> $past(msgDoneStb));

  // R9: captured word holds between captures
  a_r9_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tagWordValid |-> $stable(tagWord));

endmodule

// File: rtl/msg_time_tag.sv
module msg_time_tag
  import tt_pkg::*;
#(
  parameter int CLK_PER_US = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  resCode,
  input  logic        swStepMode,
  input  logic        syncClrEn,
  input  logic        syncLoadEn,
  input  logic        hostWrEn,
  input  logic [15:0] hostWrData,
  input  logic        swIncStb,
  input  logic        syncNoDataStb,
  input  logic        syncDataStb,
  input  logic [15:0] syncDataWord,
  input  logic        msgDoneStb,
  output logic [15:0] tagCount,
  output logic        rolloverEvt,
  output logic        tagWordValid,
  output logic [15:0] tagWord
);

  ttStrobe_t strobes;

  tt_ctrl #(.CLK_PER_US(CLK_PER_US)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .resCode      (resCode),
    .swStepMode   (swStepMode),
    .syncClrEn    (syncClrEn),
    .syncLoadEn   (syncLoadEn),
    .hostWrEn     (hostWrEn),
    .swIncStb     (swIncStb),
    .syncNoDataStb(syncNoDataStb),
    .syncDataStb  (syncDataStb),
    .strobes      (strobes)
  );

  tt_datapath dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .hostWrData  (hostWrData),
    .syncDataWord(syncDataWord),
    .msgDoneStb  (msgDoneStb),
    .count       (tagCount),
    .rolloverEvt (rolloverEvt),
    .tagWordValid(tagWordValid),
    .tagWord     (tagWord)
  );

endmodule

// File: tb/msg_time_tag_tb_top.sv
module msg_time_tag_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  resCode = 3'd0;
  logic        swStepMode = 1'b0;
  logic        syncClrEn = 1'b0;
  logic        syncLoadEn = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = 16'h0;
  logic        swIncStb = 1'b0;
  logic        syncNoDataStb = 1'b0;
  logic        syncDataStb = 1'b0;
  logic [15:0] syncDataWord = 16'h0;
  logic        msgDoneStb = 1'b0;
  logic [15:0] tagCount;
  logic        rolloverEvt;
  logic        tagWordValid;
  logic [15:0] tagWord;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 0;
  string curReq  = "R1";

  // behavioural reference state
  int mUs = 0, mPre = 0, mCount = 0, mTag = 0;
  bit mRoll = 0, mValid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_time_tag #(.CLK_PER_US(CPU)) dut_i (.*);

  task automatic check(input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // Reference model and per-clock comparison
  always @(posedge clk) begin
    if (!rst_n) begin
      mUs = 0; mPre = 0; mCount = 0; mTag = 0; mRoll = 0; mValid = 0;
    end else begin
      int periodUs;
      bit restart, step;
      periodUs = 2 << ((resCode > 5) ? 5 : resCode);  // R2 resolutions
      restart  = hostWrEn || (syncLoadEn && syncDataStb) || (syncClrEn && syncNoDataStb);
      step = 0;
      if (!restart) begin
        if (swStepMode) step = swIncStb;          // R4, R5
        else step = (mUs == CPU-1) && (mPre >= periodUs-1);
      end
      mRoll  = step && (mCount == 16'hFFFF);      // R8
      mValid = msgDoneStb;                        // R9
      if (msgDoneStb) mTag = mCount;
      if (restart || swStepMode) begin
        mUs = 0; mPre = 0;
      end else if (mUs == CPU-1) begin
        mUs = 0;
        mPre = (mPre >= periodUs-1) ? 0 : mPre + 1;
      end else begin
        mUs = mUs + 1;
      end
      if (hostWrEn) mCount = hostWrData;                          // R3
      else if (syncLoadEn && syncDataStb) mCount = syncDataWord;  // R7
      else if (syncClrEn && syncNoDataStb) mCount = 0;            // R6
      else if (step) mCount = (mCount + 1) & 16'hFFFF;
    end
    #1;
    if (!done) begin
      check("tagCount", tagCount, mCount);
      check("rolloverEvt", rolloverEvt, mRoll);
      check("tagWordValid", tagWordValid, mValid);
      check("tagWord", tagWord, mTag);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [15:0] v);
    @(negedge clk); hostWrEn = 1; hostWrData = v;
    @(negedge clk); hostWrEn = 0;
  endtask

  task automatic pulseSwInc();
    @(negedge clk); swIncStb = 1;
    @(negedge clk); swIncStb = 0;
  endtask

  task automatic pulseMsg();
    @(negedge clk); msgDoneStb = 1;
    @(negedge clk); msgDoneStb = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    idle(3);
    #2;
    check("reset tagCount", tagCount, 0);
    check("reset tagWord", tagWord, 0);
    @(negedge clk); rst_n = 1;
    idle(2);

    // R2: each resolution, including saturating codes
    curReq = "R2";
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); resCode = 3'(c);
      idle(300 + c * 60);
    end
    resCode = 3'd1;
    idle(100);

    // R3: host write mid-period restarts timebase
    curReq = "R3";
    idle(3);
    hostWrite(16'h1234);
    idle(37);
    hostWrite(16'h00A0);
    idle(50);

    // R5: software strobe ignored in free run
    curReq = "R5";
    for (int i = 0; i < 6; i++) begin pulseSwInc(); idle(3); end

    // R4: step mode, then leave it
    curReq = "R4";
    @(negedge clk); swStepMode = 1;
    idle(40);
    for (int i = 0; i < 5; i++) begin pulseSwInc(); idle(i); end
    @(negedge clk); swIncStb = 1;
    idle(4);
    swIncStb = 0;
    idle(5);
    swStepMode = 0;
    idle(60);

    // R6: synchronize clear, disabled then enabled
    curReq = "R6";
    @(negedge clk); syncNoDataStb = 1;
    @(negedge clk); syncNoDataStb = 0;
    idle(5);
    syncClrEn = 1;
    idle(11);
    syncNoDataStb = 1;
    @(negedge clk); syncNoDataStb = 0;
    idle(40);

    // R7: synchronize load, disabled, enabled, and against clear and host
    curReq = "R7";
    syncDataWord = 16'hBEEF;
    @(negedge clk); syncDataStb = 1;
    @(negedge clk); syncDataStb = 0;
    idle(5);
    syncLoadEn = 1;
    syncDataStb = 1;
    @(negedge clk); syncDataStb = 0;
    idle(20);
    syncDataWord = 16'h5A5A;
    syncDataStb = 1; syncNoDataStb = 1;
    @(negedge clk); syncDataStb = 0; syncNoDataStb = 0;
    idle(10);
    syncDataStb = 1; hostWrEn = 1; hostWrData = 16'h7777;
    @(negedge clk); syncDataStb = 0; hostWrEn = 0;
    idle(30);

    // R8: free-running wrap, step-mode wrap, write over all ones
    curReq = "R8";
    @(negedge clk); resCode = 3'd0;
    hostWrite(16'hFFFD);
    idle(60);
    @(negedge clk); swStepMode = 1;
    hostWrite(16'hFFFF);
    pulseSwInc();
    idle(4);
    hostWrite(16'hFFFF);
    hostWrite(16'h0000);
    idle(4);
    swStepMode = 0;
    idle(20);

    // R9: captures around increments and back to back
    curReq = "R9";
    for (int i = 0; i < 6; i++) begin pulseMsg(); idle(i * 3 + 1); end
    @(negedge clk); msgDoneStb = 1;
    idle(3);
    msgDoneStb = 0;
    idle(20);

    done = 1;
    summary();
    $finish;
  end

endmodule